// File: doc/BRIEF.md
# Windowed Convolution Multiply-Accumulate Engine

This engine computes one convolution response: the sum of products between a square window of an image and a mask of the same size. The two operands live in two separate dual-port memories. A host fills them through their other ports. The engine reads only through its own address/data pair on each memory. Both memories have a one-cycle synchronous read.

The host uses a small register bus. It programs the start address of the window in the image memory, the start address of the mask in the mask memory, and the row pitch of the image. It then writes the start bit. The engine sweeps both operands column by column within each row, and row by row. One shared multiplier handles one product per cycle. When the final product has been added, the signed sum is stored and a done flag is raised; the host reads both through the same bus.

The host may sit in another clock domain. Its only contact with the engine is through the memories and these registers.

Top module: `conv_macc_engine`

## Requirements
- R1: After reset, the status register (select 1) reads 0, the result registers (selects 5 and 6) read 0, and the configuration registers (selects 2, 3 and 4) read 0.
- R2: A write to the control register (select 0) with bit 0 set, while idle, is accepted at that clock edge. From the next cycle, status bit 0 (busy) reads 1 and status bit 1 (done) reads 0.
- R3: During a run, the image address for window element (row r, column c) is image_base + r*pitch + c, taken modulo 2^ADDR_W. Columns advance first, then rows. A new address is presented on every cycle of the sweep.
- R4: The mask is stored contiguously. Element (r, c) is read at mask_base + r*DIM + c, modulo 2^ADDR_W, in the same cycle as the matching image address.
- R5: The result is the exact signed sum, over all DIM×DIM elements, of the unsigned PIX_W-bit pixel times the signed MSK_W-bit mask value. It is held in ACC_W bits with no overflow. Select 5 returns bits 31:0. Select 6 returns bits 63:32 of the value sign-extended to 64 bits.
- R6: Busy stays high for exactly DIM*DIM+1 cycles after the start is accepted, which covers the one-cycle memory read latency. In the cycle busy falls, done rises and the result is updated. Busy and done are never both 1.
- R7: A start write while busy is ignored. The sweep order and the completion cycle of the current run are unchanged.
- R8: Writes to the configuration registers during a run take effect only at the next accepted start. They read back at once.
- R9: The result register keeps its previous value throughout a run, and changes only when the run completes.
- R10: A control write with bit 0 clear starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Engine clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for the selected register (combinational) |
| img_addr_o | output | ADDR_W | Image memory read address |
| img_rdata_i | input | PIX_W | Image memory read data, one cycle after the address |
| msk_addr_o | output | ADDR_W | Mask memory read address |
| msk_rdata_i | input | MSK_W | Mask memory read data, one cycle after the address |

## Verification
The bench targets the extreme products. In one run every pixel is 255 and every mask value is the most negative code; in another every mask value is the most positive code. A narrow or unsigned accumulator would return a wrapped or sign-flipped sum. A window whose rows run past the top of the address space checks the wrap of the row-base arithmetic; a design that mixed up pitch and mask width would read the wrong pixels. A start issued mid-run, together with new base and pitch values, checks R7 and R8. A design that restarted or followed the live registers would finish late or return a different sum. The bench also compares the busy/done timing on every cycle, which exposes any error in the drain cycle left by the memory latency.

// File: rtl/conv_macc_pkg.sv
package conv_macc_pkg;
  localparam int unsigned BUS_W = 32;

  typedef enum logic [2:0] {
    SEL_CTRL    = 3'd0,
    SEL_STATUS  = 3'd1,
    SEL_IMG_BASE = 3'd2,
    SEL_MSK_BASE = 3'd3,
    SEL_PITCH   = 3'd4,
    SEL_RES_LO  = 3'd5,
    SEL_RES_HI  = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/conv_addr_gen.sv
module conv_addr_gen #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DIM    = 40,
  localparam int unsigned CNT_W = (DIM > 1) ? $clog2(DIM) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] img_base_i,
  input  logic [ADDR_W-1:0] msk_base_i,
  input  logic [ADDR_W-1:0] pitch_i,
  output logic              issue_o,
  output logic              last_o,
  output logic              col_last_o,
  output logic [ADDR_W-1:0] img_addr_o,
  output logic [ADDR_W-1:0] msk_addr_o
);
  logic              active_q;
  logic [CNT_W-1:0]  col_q, row_q;
  logic [ADDR_W-1:0] row_base_q, msk_ptr_q, pitch_q;
  logic              col_last, row_last;

  assign col_last = (col_q == CNT_W'(DIM - 1));
  assign row_last = (row_q == CNT_W'(DIM - 1));

  // operands latched at start; live registers do not disturb a run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      col_q      <= '0;
      row_q      <= '0;
      row_base_q <= '0;
      msk_ptr_q  <= '0;
      pitch_q    <= '0;
    end else if (start_i) begin
      active_q   <= 1'b1;
      col_q      <= '0;
      row_q      <= '0;
      row_base_q <= img_base_i;
      msk_ptr_q  <= msk_base_i;
      pitch_q    <= pitch_i;
    end else if (active_q) begin
      msk_ptr_q <= msk_ptr_q + 1'b1;
      if (col_last) begin
        col_q      <= '0;
        row_base_q <= row_base_q + pitch_q;
        if (row_last) active_q <= 1'b0;
        else          row_q    <= row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  assign issue_o    = active_q;
  assign last_o     = active_q && col_last && row_last;
  assign col_last_o = col_last;
  assign img_addr_o = row_base_q + ADDR_W'(col_q);
  assign msk_addr_o = msk_ptr_q;
endmodule

// File: rtl/conv_mac_pipe.sv
module conv_mac_pipe #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned MSK_W = 16,
  parameter int unsigned ACC_W = 36,
  localparam int unsigned PROD_W = PIX_W + MSK_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    issue_i,
  input  logic                    last_i,
  input  logic [PIX_W-1:0]        pix_i,
  input  logic signed [MSK_W-1:0] msk_i,
  output logic                    fin_o,
  output logic signed [ACC_W-1:0] sum_o
);
  logic                     vld_q, lst_q;
  logic signed [ACC_W-1:0]  acc_q;
  logic signed [PROD_W-1:0] prod;

  // one cycle of memory latency: data pairs with the address issued last cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      lst_q <= 1'b0;
    end else begin
      vld_q <= issue_i;
      lst_q <= issue_i && last_i;
    end
  end

  assign prod  = $signed({1'b0, pix_i}) * msk_i;
  assign sum_o = acc_q + ACC_W'(prod);
  assign fin_o = vld_q && lst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (vld_q)   acc_q <= sum_o;
  end
endmodule

// File: rtl/conv_regs.sv
module conv_regs
  import conv_macc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned ACC_W  = 36
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    reg_wr_i,
  input  logic [2:0]              reg_addr_i,
  input  logic [BUS_W-1:0]        reg_wdata_i,
  output logic [BUS_W-1:0]        reg_rdata_o,
  input  logic                    fin_i,
  input  logic signed [ACC_W-1:0] sum_i,
  output logic                    start_o,
  output logic [ADDR_W-1:0]       img_base_o,
  output logic [ADDR_W-1:0]       msk_base_o,
  output logic [ADDR_W-1:0]       pitch_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic signed [ACC_W-1:0] result_o
);
  logic                    busy_q, done_q;
  logic [ADDR_W-1:0]       img_base_q, msk_base_q, pitch_q;
  logic signed [ACC_W-1:0] result_q;
  logic [63:0]             res_ext;
  logic                    unused_wdata;

  assign unused_wdata = ^reg_wdata_i[BUS_W-1:ADDR_W];

  assign start_o = reg_wr_i && (reg_addr_i == SEL_CTRL) && reg_wdata_i[0] && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      result_q <= '0;
    end else if (start_o) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (fin_i) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b1;
      result_q <= sum_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      img_base_q <= '0;
      msk_base_q <= '0;
      pitch_q    <= '0;
    end else if (reg_wr_i) begin
      case (reg_addr_i)
        SEL_IMG_BASE: img_base_q <= reg_wdata_i[ADDR_W-1:0];
        SEL_MSK_BASE: msk_base_q <= reg_wdata_i[ADDR_W-1:0];
        SEL_PITCH:    pitch_q    <= reg_wdata_i[ADDR_W-1:0];
        default: ;
      endcase
    end
  end

  assign res_ext = {{(64-ACC_W){result_q[ACC_W-1]}}, result_q};

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      SEL_STATUS:   reg_rdata_o = {{(BUS_W-2){1'b0}}, done_q, busy_q};
      SEL_IMG_BASE: reg_rdata_o = BUS_W'(img_base_q);
      SEL_MSK_BASE: reg_rdata_o = BUS_W'(msk_base_q);
      SEL_PITCH:    reg_rdata_o = BUS_W'(pitch_q);
      SEL_RES_LO:   reg_rdata_o = res_ext[31:0];
      SEL_RES_HI:   reg_rdata_o = res_ext[63:32];
      default:      reg_rdata_o = '0;
    endcase
  end

  assign img_base_o = img_base_q;
  assign msk_base_o = msk_base_q;
  assign pitch_o    = pitch_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign result_o   = result_q;
endmodule

// File: rtl/conv_macc_engine.sv
module conv_macc_engine #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned MSK_W  = 16,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DIM    = 40,
  parameter int unsigned ACC_W  = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic [ADDR_W-1:0] img_addr_o,
  input  logic [PIX_W-1:0]  img_rdata_i,
  output logic [ADDR_W-1:0] msk_addr_o,
  input  logic [MSK_W-1:0]  msk_rdata_i
);
  logic              start_acc, busy, done, issue, last, col_last, fin;
  logic [ADDR_W-1:0] img_base, msk_base, pitch;
  logic signed [ACC_W-1:0] sum, result;

  conv_regs #(.ADDR_W(ADDR_W), .ACC_W(ACC_W)) regs_i (
    .clk_i, .rst_ni, .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .fin_i(fin), .sum_i(sum), .start_o(start_acc),
    .img_base_o(img_base), .msk_base_o(msk_base), .pitch_o(pitch),
    .busy_o(busy), .done_o(done), .result_o(result)
  );

  conv_addr_gen #(.ADDR_W(ADDR_W), .DIM(DIM)) agen_i (
    .clk_i, .rst_ni, .start_i(start_acc),
    .img_base_i(img_base), .msk_base_i(msk_base), .pitch_i(pitch),
    .issue_o(issue), .last_o(last), .col_last_o(col_last),
    .img_addr_o, .msk_addr_o
  );

  conv_mac_pipe #(.PIX_W(PIX_W), .MSK_W(MSK_W), .ACC_W(ACC_W)) mac_i (
    .clk_i, .rst_ni, .clear_i(start_acc), .issue_i(issue), .last_i(last),
    .pix_i(img_rdata_i), .msk_i($signed(msk_rdata_i)),
    .fin_o(fin), .sum_o(sum)
  );
endmodule

// File: rtl/conv_macc_checker.sv
module conv_macc_checker #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned ACC_W  = 36
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_i,
  input logic              done_i,
  input logic              issue_i,
  input logic              last_i,
  input logic              col_last_i,
  input logic [ADDR_W-1:0] img_addr_i,
  input logic [ADDR_W-1:0] msk_addr_i,
  input logic [ACC_W-1:0]  result_i
);
  // R6
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_i && done_i));

  // R2
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (busy_i && !done_i));

  // R6
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> $fell(busy_i));

  // R9
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> $stable(result_i));

  // R4
  msk_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && !last_i) |=> (msk_addr_i == ADDR_W'($past(msk_addr_i) + 1'b1)));

  // R3
  img_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && !col_last_i) |=> (img_addr_i == ADDR_W'($past(img_addr_i) + 1'b1)));
endmodule

bind conv_macc_engine conv_macc_checker #(.ADDR_W(ADDR_W), .ACC_W(ACC_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_acc), .busy_i(busy), .done_i(done),
  .issue_i(issue), .last_i(last), .col_last_i(col_last),
  .img_addr_i(img_addr_o), .msk_addr_i(msk_addr_o), .result_i(result)
);

// File: tb/conv_macc_engine_tb_top.sv
module conv_macc_engine_tb_top;
  localparam int ADDR_W = 12;
  localparam int DIM    = 40;
  localparam int NT     = DIM * DIM;
  localparam int MEM_D  = 1 << ADDR_W;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic reg_wr_i = 1'b0;
  logic [2:0] reg_addr_i = 3'd1;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic [ADDR_W-1:0] img_addr_o, msk_addr_o;
  logic [7:0]  img_q = '0;
  logic [15:0] msk_q = '0;

  logic [7:0]         img_mem [MEM_D];
  logic signed [15:0] msk_mem [MEM_D];

  int compared = 0, mismatched = 0, wd = 0;
  bit finished = 0;

  // reference model state
  bit     m_busy = 0, m_done = 0;
  int     m_cycle = 0;
  int     m_img = 0, m_msk = 0, m_pitch = 0;
  int     l_img = 0, l_msk = 0, l_pitch = 0;
  longint m_res = 0, m_pend = 0;

  always #5 clk = ~clk;

  conv_macc_engine dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .img_addr_o(img_addr_o), .img_rdata_i(img_q),
    .msk_addr_o(msk_addr_o), .msk_rdata_i(msk_q)
  );

  always @(posedge clk) begin
    img_q <= img_mem[img_addr_o];
    msk_q <= msk_mem[msk_addr_o];
  end

  task automatic chk(string tag, longint got, longint exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural model, advanced on every clock edge
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_done = 0; m_cycle = 0; m_res = 0;
      m_img = 0; m_msk = 0; m_pitch = 0;
    end else begin
      if (reg_wr_i && reg_addr_i == 3'd0 && reg_wdata_i[0] && !m_busy) begin
        m_busy = 1; m_done = 0; m_cycle = 0;
        l_img = m_img; l_msk = m_msk; l_pitch = m_pitch;
        m_pend = 0;
        for (int r = 0; r < DIM; r++)
          for (int c = 0; c < DIM; c++)
            m_pend += longint'(img_mem[(l_img + r * l_pitch + c) % MEM_D]) *
                      longint'(msk_mem[(l_msk + r * DIM + c) % MEM_D]);
      end else if (m_busy) begin
        m_cycle++;
        if (m_cycle == NT + 1) begin
          m_busy = 0; m_done = 1; m_res = m_pend;
        end
      end
      if (reg_wr_i) begin
        if (reg_addr_i == 3'd2) m_img   = int'(reg_wdata_i[ADDR_W-1:0]);
        if (reg_addr_i == 3'd3) m_msk   = int'(reg_wdata_i[ADDR_W-1:0]);
        if (reg_addr_i == 3'd4) m_pitch = int'(reg_wdata_i[ADDR_W-1:0]);
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      if (!reg_wr_i && reg_addr_i == 3'd1)
        chk("R6 status", longint'(reg_rdata_o), longint'({m_done, m_busy}));
      if (m_busy && m_cycle < NT) begin
        chk("R3 img addr", longint'(img_addr_o),
            longint'((l_img + (m_cycle / DIM) * l_pitch + (m_cycle % DIM)) % MEM_D));
        chk("R4 msk addr", longint'(msk_addr_o), longint'((l_msk + m_cycle) % MEM_D));
      end
    end
  end

  task automatic summary();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd == 150000 && !finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic wr(int a, int d);
    @(posedge clk); #2;
    reg_wr_i = 1'b1; reg_addr_i = 3'(a); reg_wdata_i = 32'(d);
    @(posedge clk); #2;
    reg_wr_i = 1'b0; reg_addr_i = 3'd1;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(posedge clk); #2;
    reg_addr_i = 3'(a);
    @(negedge clk);
    d = reg_rdata_o;
    @(posedge clk); #2;
    reg_addr_i = 3'd1;
  endtask

  task automatic wait_idle();
    @(posedge clk);
    while (m_busy) @(posedge clk);
    #2;
  endtask

  task automatic check_result(string tag);
    logic [31:0] lo, hi;
    rd(5, lo);
    rd(6, hi);
    chk(tag, longint'({hi, lo}), m_res);
  endtask

  task automatic start_run();
    logic [31:0] s;
    wr(0, 1);
    rd(1, s);
    chk("R2 busy after start", longint'(s[1:0]), 64'd1);
  endtask

  task automatic fill_pattern();
    for (int i = 0; i < MEM_D; i++) begin
      img_mem[i] = 8'((i * 37 + 5) & 255);
      msk_mem[i] = 16'((i * 131) ^ 16'h5a5a);
    end
  endtask

  task automatic fill_const(logic [7:0] p, logic signed [15:0] m);
    for (int i = 0; i < MEM_D; i++) begin
      img_mem[i] = p;
      msk_mem[i] = m;
    end
  endtask

  initial begin
    logic [31:0] d;
    fill_pattern();
    repeat (3) @(posedge clk);
    #2 rst_ni = 1'b1;

    // R1 reset values
    for (int a = 1; a <= 6; a++) begin
      rd(a, d);
      chk("R1 reset register", longint'(d), 0);
    end

    // R10 control write without start bit
    wr(0, 32'h2);
    repeat (4) @(posedge clk);
    rd(1, d);
    chk("R10 no start", longint'(d), 0);

    // run A: patterned data
    wr(2, 12'h010); wr(3, 12'h800); wr(4, 64);
    start_run();
    wait_idle();
    rd(1, d);
    chk("R6 done after run", longint'(d), 2);
    check_result("R5 patterned sum");

    // run B: extreme negative products, window wraps address space (R3)
    fill_const(8'd255, -16'sd32768);
    wr(2, 12'hF00); wr(3, 12'h100); wr(4, 70);
    start_run();
    wait_idle();
    check_result("R5 negative extreme");

    // run C: extreme positive, mid-run start and config writes
    fill_const(8'd255, 16'sd32767);
    wr(2, 12'h200); wr(3, 12'h300); wr(4, 50);
    start_run();
    repeat (100) @(posedge clk);
    rd(5, d);
    chk("R9 result held mid-run", longint'(d), longint'(m_res & 64'hFFFF_FFFF));
    wr(0, 1);                 // R7 ignored start
    wr(2, 12'h123);           // R8 late config
    wr(4, 3);
    rd(2, d);
    chk("R8 readback during run", longint'(d), 64'h123);
    wait_idle();
    check_result("R5 R7 R8 positive extreme");

    // run D: new config takes effect at next start; done clears on start
    fill_pattern();
    start_run();
    wait_idle();
    check_result("R8 R5 run with new config");

    repeat (3) @(posedge clk);
    summary();
  end
endmodule